// File: doc/BRIEF.md
# Serial-Bus Register Slave for an LED Driver Controller

This block is the write side of a two-wire serial control port (I2C-compatible) that configures an LED driver. A fast system clock samples the bus clock and data lines through two-flop synchronizers. The block detects start, repeated start and stop conditions and checks the first byte against a fixed 7-bit device address. When that byte names the device for a write, the next byte selects a register and the byte after it is stored there.

The block acknowledges each accepted byte by asserting an open-drain enable, which pulls the data line low during the ninth bus clock. There are three control registers at sparse addresses. The enable register holds the main-bank enable, the auxiliary enable and the fifth-channel sense enable. The main brightness register holds a 5-bit level and the auxiliary brightness register holds a 2-bit level. Bits that store nothing always read as fixed values. The active-low reset is synchronous and puts every register back to its power-on value.

Top module: `led_ctl_i2c_slave`

## Requirements
- R1: A first byte of 0110110 followed by a 0 direction bit is acknowledged: `sda_oe` is high while SCL is high on the ninth clock.
- R2: If the first byte holds another address, or has direction bit 1, it is not acknowledged. No register changes until the next start.
- R3: After an accepted address, the register-select byte and the data byte are both acknowledged. The data byte is written to the selected register when that byte completes.
- R4: Register 10h is the enable register, with power-on value 20h. Its fields are: bit 0 main enable, bit 2 auxiliary enable, bit 3 fifth-channel sense enable. Bits 1 and 4 are test bits and always read 0. Bits 7:5 always read 001.
- R5: Register A0h is the main brightness register, with power-on value E0h. Bits 4:0 hold the level. Bits 7:5 always read 111.
- R6: Register C0h is the auxiliary brightness register, with power-on value FCh. Bits 1:0 hold the level. Bits 7:2 always read 1.
- R7: A register-select byte that names none of the three registers is still acknowledged, together with its data byte. No register changes.
- R8: A repeated start at any point restarts the address phase, exactly as a first start does.
- R9: A stop ends the transfer at once and releases `sda_oe`. A transfer stopped before its data byte completes writes nothing.
- R10: When `rst_n` is sampled low, all three registers return to 20h, E0h and FCh on that clock edge.
- R11: Bytes are shifted in most significant bit first. Data is sampled on the rising edge of the synchronized SCL.
- R12: Bytes after the data byte within the same transfer are not acknowledged and change no register.
- R13: `sda_oe` changes only on the clock after a synchronized SCL falling edge, a start, a stop or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| gp_reg | output | 8 | Enable register contents |
| main_reg | output | 8 | Main brightness register contents |
| aux_reg | output | 8 | Auxiliary brightness register contents |

## Verification
Writes go to all three registers with all-ones, all-zeros and asymmetric data such as 01h and 15h. The asymmetric values separate a correct shift order from a reversed one, and they show whether the test bits and the fixed bits stay pinned. Error-path transfers use a neighbouring device address, a read request, an unmapped register select and an extra trailing byte. In each case the acknowledge on the wire is checked and all three registers are re-read. Interrupted transfers cover a repeated start after the register byte and a stop before the data byte. A reset pulse after the registers were written returns all three to their power-on values.

// File: rtl/led_i2c_pkg.sv
// Package: constants and types shared by the LED controller's serial slave.
// Assumes an 8-bit register space, with three mapped registers at sparse addresses.
package led_i2c_pkg;

    localparam int          BYTE_W     = 8;
    localparam logic [6:0]  DEV_ADDR   = 7'h36;

    localparam logic [7:0]  RA_GP      = 8'h10;
    localparam logic [7:0]  RA_MAIN    = 8'hA0;
    localparam logic [7:0]  RA_AUX     = 8'hC0;

    localparam int          MAIN_LVL_W = 5;
    localparam int          AUX_LVL_W  = 2;

    // Transfer phases of the write engine.
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_ADDR,
        XS_REGSEL,
        XS_DATA,
        XS_SKIP
    } xfer_st_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Synchronizes the bus clock and data lines into the system clock domain.
// It flags a falling and a rising bus-clock edge, a start (data falling
// while the clock is high) and a stop (data rising while the clock is high).
// Assumes each bus edge is held for several system clocks. Both lines pass
// through chains of equal length, so their relative order is preserved.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;
    logic              scl_now;

    // Shift both lines through their synchronizer chains; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
    end

    assign scl_now = scl_chain[STAGES-1];
    assign sda_s   = sda_chain[STAGES-1];

    // Keep the previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_now;
            sda_q <= sda_s;
        end
    end

    // Decode the edges and the bus conditions from old and new samples.
    always_comb begin
        scl_rise  = scl_now & ~scl_q;
        scl_fall  = ~scl_now & scl_q;
        start_det = scl_now & scl_q & sda_q & ~sda_s;
        stop_det  = scl_now & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_wr_engine.sv
// Module: i2c_wr_engine
// Byte-level write protocol: device address, register select, then data.
// It acknowledges by raising sda_oe after the eighth falling edge and drops
// it after the ninth. It issues a one-cycle write strobe when the data byte
// completes. Assumes edge and condition pulses are one system clock wide.
module i2c_wr_engine
    import led_i2c_pkg::*;
#(
    parameter int         W       = BYTE_W,
    parameter logic [6:0] MY_ADDR = DEV_ADDR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sda_s,
    input  logic         scl_rise,
    input  logic         scl_fall,
    input  logic         start_det,
    input  logic         stop_det,
    output logic         sda_oe,
    output logic         wr_en,
    output logic [W-1:0] wr_addr,
    output logic [W-1:0] wr_data
);

    localparam int               CNT_W    = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

    xfer_st_t         st;
    xfer_st_t         st_next;
    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     shreg;
    logic [W-1:0]     regsel;
    logic             in_ack;
    logic             ack_now;
    logic             receiving;

    // Decide the acknowledge and the phase that follows the current byte.
    always_comb begin
        ack_now = 1'b0;
        st_next = XS_SKIP;
        unique case (st)
            XS_ADDR: begin
                ack_now = (shreg == {MY_ADDR, 1'b0});
                st_next = ack_now ? XS_REGSEL : XS_SKIP;
            end
            XS_REGSEL: begin
                ack_now = 1'b1;
                st_next = XS_DATA;
            end
            XS_DATA: begin
                ack_now = 1'b1;
                st_next = XS_SKIP;
            end
            default: begin
                ack_now = 1'b0;
                st_next = st;
            end
        endcase
    end

    assign receiving = (st == XS_ADDR) || (st == XS_REGSEL) || (st == XS_DATA);

    // Sequence the bit count, the ack slot and the phases; strobe the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= XS_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            regsel  <= '0;
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                st      <= XS_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                st      <= XS_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (receiving) begin
                if (scl_rise && (bit_cnt < CNT_FULL)) begin
                    shreg   <= {shreg[W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall && (bit_cnt == CNT_FULL) && !in_ack) begin
                    in_ack <= 1'b1;
                    sda_oe <= ack_now;
                    if (st == XS_REGSEL) begin
                        regsel <= shreg;
                    end
                    if (st == XS_DATA) begin
                        wr_en   <= 1'b1;
                        wr_addr <= regsel;
                        wr_data <= shreg;
                    end
                end else if (scl_fall && in_ack) begin
                    in_ack  <= 1'b0;
                    sda_oe  <= 1'b0;
                    bit_cnt <= '0;
                    st      <= st_next;
                end
            end
        end
    end

endmodule

// File: rtl/led_ctl_regs.sv
// Module: led_ctl_regs
// The three control registers. Only the implemented bits are stored, and the
// read value is assembled with fixed bits around them. The test bits are held at 0.
// Assumes a one-cycle write strobe; unmapped addresses are dropped.
module led_ctl_regs
    import led_i2c_pkg::*;
#(
    parameter int MAIN_W = MAIN_LVL_W,
    parameter int AUX_W  = AUX_LVL_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic [7:0]  gp_q,
    output logic [7:0]  main_q,
    output logic [7:0]  aux_q
);

    localparam int MAIN_PAD = BYTE_W - MAIN_W;
    localparam int AUX_PAD  = BYTE_W - AUX_W;

    logic              en_main;
    logic              en_aux;
    logic              en_d5;
    logic [MAIN_W-1:0] main_lvl;
    logic [AUX_W-1:0]  aux_lvl;

    // Store the implemented fields on a write to a mapped address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_main  <= 1'b0;
            en_aux   <= 1'b0;
            en_d5    <= 1'b0;
            main_lvl <= '0;
            aux_lvl  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                RA_GP: begin
                    en_main <= wr_data[0];
                    en_aux  <= wr_data[2];
                    en_d5   <= wr_data[3];
                end
                RA_MAIN: main_lvl <= wr_data[MAIN_W-1:0];
                RA_AUX:  aux_lvl  <= wr_data[AUX_W-1:0];
                default: ;
            endcase
        end
    end

    // Assemble the visible register images with their fixed bits.
    always_comb begin
        gp_q   = {3'b001, 1'b0, en_d5, en_aux, 1'b0, en_main};
        main_q = {{MAIN_PAD{1'b1}}, main_lvl};
        aux_q  = {{AUX_PAD{1'b1}}, aux_lvl};
    end

endmodule

// File: rtl/led_ctl_i2c_slave.sv
// Module: led_ctl_i2c_slave (top)
// Write-only serial register slave for the LED driver controller. It joins the
// line synchronizer, the byte-level write engine and the register bank.
// Assumes the system clock runs at least about 8x faster than the bus clock.
module led_ctl_i2c_slave
    import led_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] gp_reg,
    output logic [7:0] main_reg,
    output logic [7:0] aux_reg
);

    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_wr_engine #(.W(BYTE_W), .MY_ADDR(DEV_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    led_ctl_regs #(.MAIN_W(MAIN_LVL_W), .AUX_W(AUX_LVL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .gp_q    (gp_reg),
        .main_q  (main_reg),
        .aux_q   (aux_reg)
    );

endmodule

// File: rtl/led_ctl_i2c_slave_chk.sv
// Module: led_ctl_i2c_slave_chk
// Property checker bound to the top. It watches the bus conditions, the
// acknowledge enable and the register images.
module led_ctl_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] gp_reg,
    input logic [7:0] main_reg,
    input logic [7:0] aux_reg
);

    logic rst_seen;

    // Remember that reset was sampled low on the previous edge.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
        if (rst_seen) begin
            assert_por_values_R10: assert (gp_reg == 8'h20 && main_reg == 8'hE0 && aux_reg == 8'hFC)
                else $error("registers not at power-on values after reset");
        end
    end

    assert_fixed_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_reg[7:5] == 3'b001) && !gp_reg[4] && !gp_reg[1])
        else $error("enable register fixed or test bits disturbed");

    assert_fixed_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        main_reg[7:5] == 3'b111)
        else $error("main brightness fixed bits disturbed");

    assert_fixed_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        aux_reg[7:2] == 6'h3F)
        else $error("aux brightness fixed bits disturbed");

    assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(gp_reg) && $stable(main_reg) && $stable(aux_reg)))
        else $error("register changed without a write strobe");

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe)
        else $error("acknowledge still driven after stop");

    assert_cond_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det}))
        else $error("start and stop flagged together");

    assert_oe_timing_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)))
        else $error("acknowledge enable changed outside a clock-low slot");

endmodule

bind led_ctl_i2c_slave led_ctl_i2c_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .gp_reg    (gp_reg),
    .main_reg  (main_reg),
    .aux_reg   (aux_reg)
);

// File: tb/led_ctl_i2c_slave_tb.sv
// Directed bench: one task for each scenario, bus modelled as a wired-AND.
module led_ctl_i2c_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam logic [7:0] WADDR = 8'h6C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] gp_reg;
    logic [7:0] main_reg;
    logic [7:0] aux_reg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    led_ctl_i2c_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .gp_reg   (gp_reg),
        .main_reg (main_reg),
        .aux_reg  (aux_reg)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        m_sda = 1'b0; wait_q(1);
        m_scl = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        m_sda = 1'b1; wait_q(2);
    endtask

    // Sends one byte MSB first and returns the acknowledge seen on the wire;
    // oe_bad is set if the slave pulls the line during a data bit.
    task automatic send_byte(input logic [7:0] b, output logic acked, output logic oe_bad);
        oe_bad = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_q(1);
            m_scl = 1'b1; wait_q(1);
            if (sda_oe) oe_bad = 1'b1;
            wait_q(1);
            m_scl = 1'b0; wait_q(1);
        end
        m_sda = 1'b1; wait_q(1);
        m_scl = 1'b1; wait_q(1);
        acked = (sda_line == 1'b0);
        wait_q(1);
        m_scl = 1'b0; wait_q(1);
    endtask

    task automatic write_reg(input logic [7:0] ra, input logic [7:0] d, input string req);
        logic a0, a1, a2, ob;
        bus_start();
        send_byte(WADDR, a0, ob);
        send_byte(ra, a1, ob);
        send_byte(d, a2, ob);
        bus_stop();
        chk({req, " ack pattern"}, {5'b0, a0, a1, a2}, 8'h07);
    endtask

    task automatic check_regs(input string req, input logic [7:0] g, input logic [7:0] m, input logic [7:0] a);
        chk({req, " gp"}, gp_reg, g);
        chk({req, " main"}, main_reg, m);
        chk({req, " aux"}, aux_reg, a);
    endtask

    task automatic t_reset_state();
        check_regs("R10 reset", 8'h20, 8'hE0, 8'hFC);
        chk("R13 oe idle", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_main_writes();
        logic a0, a1, a2, o0, o1, o2;
        bus_start();
        send_byte(WADDR, a0, o0);
        send_byte(8'hA0, a1, o1);
        send_byte(8'h15, a2, o2);
        bus_stop();
        chk("R1 R3 main ack", {5'b0, a0, a1, a2}, 8'h07);
        chk("R13 no oe during data bits", {5'b0, o0, o1, o2}, 8'h00);
        chk("R5 main 15h", main_reg, 8'hF5);
        write_reg(8'hA0, 8'h01, "R11");
        chk("R11 msb first", main_reg, 8'hE1);
        write_reg(8'hA0, 8'hFF, "R5");
        chk("R5 main full", main_reg, 8'hFF);
    endtask

    task automatic t_gp_writes();
        write_reg(8'h10, 8'hFF, "R4");
        chk("R4 gp all ones", gp_reg, 8'h2D);
        write_reg(8'h10, 8'h04, "R4");
        chk("R4 gp aux only", gp_reg, 8'h24);
    endtask

    task automatic t_aux_writes();
        write_reg(8'hC0, 8'hFF, "R6");
        chk("R6 aux all ones", aux_reg, 8'hFF);
        write_reg(8'hC0, 8'h02, "R6");
        chk("R6 aux 02h", aux_reg, 8'hFE);
    endtask

    task automatic t_bad_address();
        logic a0, a1, ob;
        bus_start();
        send_byte(8'h6E, a0, ob);
        send_byte(8'hA0, a1, ob);
        send_byte(8'h00, a1, ob);
        bus_stop();
        chk("R2 wrong addr nack", {7'b0, a0}, 8'h00);
        bus_start();
        send_byte(8'h6D, a0, ob);
        send_byte(8'hC0, a1, ob);
        send_byte(8'h00, a1, ob);
        bus_stop();
        chk("R2 read nack", {7'b0, a0}, 8'h00);
        check_regs("R2 untouched", 8'h24, 8'hFF, 8'hFE);
    endtask

    task automatic t_unmapped();
        write_reg(8'h11, 8'h00, "R7");
        check_regs("R7 unmapped", 8'h24, 8'hFF, 8'hFE);
    endtask

    task automatic t_repeated_start();
        logic a0, a1, a2, a3, a4, ob;
        bus_start();
        send_byte(WADDR, a0, ob);
        send_byte(8'hA0, a1, ob);
        bus_start();
        send_byte(WADDR, a2, ob);
        send_byte(8'hC0, a3, ob);
        send_byte(8'h01, a4, ob);
        bus_stop();
        chk("R8 restart acks", {3'b0, a0, a1, a2, a3, a4}, 8'h1F);
        check_regs("R8 restart", 8'h24, 8'hFF, 8'hFD);
    endtask

    task automatic t_early_stop();
        logic a0, a1, ob;
        bus_start();
        send_byte(WADDR, a0, ob);
        send_byte(8'hA0, a1, ob);
        bus_stop();
        chk("R9 oe released", {7'b0, sda_oe}, 8'h00);
        check_regs("R9 early stop", 8'h24, 8'hFF, 8'hFD);
    endtask

    task automatic t_extra_byte();
        logic a0, a1, a2, a3, ob;
        bus_start();
        send_byte(WADDR, a0, ob);
        send_byte(8'hA0, a1, ob);
        send_byte(8'h03, a2, ob);
        send_byte(8'h1C, a3, ob);
        bus_stop();
        chk("R12 trailing nack", {4'b0, a0, a1, a2, a3}, 8'h0E);
        chk("R12 main keeps data byte", main_reg, 8'hE3);
    endtask

    task automatic t_reset_pulse();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check_regs("R10 reset pulse", 8'h20, 8'hE0, 8'hFC);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset_state();
        t_main_writes();
        t_gp_writes();
        t_aux_writes();
        t_bad_address();
        t_unmapped();
        t_repeated_start();
        t_early_stop();
        t_extra_byte();
        t_reset_pulse();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule